// File: doc/BRIEF.md
# Locality Access Gate

The gate sits behind a host-bus cycle decoder in a trusted-module front end. For every decoded register access it decides whether the access is performed or dropped. A dropped access gets no bus acknowledge, and no register or ownership state changes. The decision depends on three things: which register is addressed, whether the access reads or writes, and how the requesting locality relates to the current owner. The relation is one of three: the requester owns, another locality owns, or nobody owns. The gate also holds the ownership state itself. It changes that state on claim and relinquish writes to the access-control register, and on the writes to the hash-sequence registers that implicitly take and give back locality 4.

Ownership is kept by a three-state machine:
- `OWN_FREE`: no locality is active.
- `OWN_HELD`: a locality won ownership with a claim write.
- `OWN_HASH`: locality 4 took ownership through a hash-start write.

The transitions are:
- FREE→HELD on an accepted claim.
- FREE→HASH and HELD→HASH on an accepted hash start.
- HELD→FREE on an owner relinquish, or on a hash end while locality 4 owns.
- HASH→FREE on a hash end or an owner relinquish.
- HASH→HASH on a repeated hash start.

Each request is answered one cycle later by a registered response.

Top module: `loc_access_gate`

Register selector codes:

| Code | Register |
|---|---|
| 0 | status |
| 1 | interrupt enable |
| 2 | interrupt vector |
| 3 | interrupt status |
| 4 | interrupt capability |
| 5 | access control |
| 6 | data FIFO |
| 7 | configuration |
| 8 | hash start |
| 9 | hash data |
| 10 | hash end |
| 11 to 15 | undefined |

Bit 0 of write data on the access-control register is claim. Bit 1 is relinquish.

## Requirements
- R1: A status access (code 0), read or write, is accepted only from the owning locality.
- R2: Interrupt enable (1), interrupt vector (2) and configuration (7) reads are accepted from any locality. Their writes are accepted only from the owner.
- R3: Interrupt status (3) reads are accepted from any locality. An owner write is accepted and pulses `int_clear` for one cycle, with `int_clear_mask` equal to the write data. Writes from a non-owner abort and give no pulse.
- R4: Interrupt capability (4) reads are accepted from any locality. Every write to it aborts.
- R5: Access-control (5) reads and writes are always accepted. A write with bit 0 set makes the writer the owner when no locality owns. A write with bit 1 set from the owner leaves no owner. Relinquish wins when both bits are set. Claims made while another locality owns are dropped.
- R6: Data FIFO (6) reads are accepted only from the owner while `data_avail` is 1. FIFO writes are accepted only from the owner.
- R7: Hash start (8) writes are accepted from the owner or when no locality owns, and make locality 4 the owner. Reads of it abort.
- R8: Hash data (9) and hash end (10) writes are accepted only from the owner. An accepted hash end leaves no owner if locality 4 owned. Reads of codes 8 to 10 abort.
- R9: An aborted access changes neither the ownership outputs nor `int_clear`.
- R10: A locality field above 4, or a selector code of 11 to 15, always aborts.
- R11: After reset no locality owns, and no response or clear pulse is driven.
- R12: Every request gets exactly one response on the next cycle, with exactly one of accept or abort set. No response is driven without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A decoded register access is presented this cycle |
| req_loc_nib | input | 4 | Cycle address bits [15:12], the requesting locality |
| req_reg | input | 4 | Register selector code |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data (claim/relinquish bits, interrupt clear mask) |
| data_avail | input | 1 | Data FIFO has response data to read |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_accept | output | 1 | Access performed |
| rsp_abort | output | 1 | Access dropped, no acknowledge |
| int_clear | output | 1 | Clear written interrupt status bits |
| int_clear_mask | output | 8 | Bits to clear |
| owner_valid | output | 1 | Some locality is active |
| owner_loc | output | 3 | Active locality number |

## Verification
Some rules hold without reference to the table, and the assertions check them on every cycle:
- the one-cycle response timing and exclusive accept/abort;
- aborts for out-of-range localities and for FIFO reads with no data;
- unchanged ownership after an abort;
- clear pulses only on accepted accesses;
- locality 4 ownership after any accepted hash start.

Other behaviour only shows up in the bench's scenarios, which compare against a table model across a sweep of every register, direction, data-available value and ownership relation:
- the full per-register ownership matrix;
- claim and relinquish priority;
- the implicit release by hash end.

// File: rtl/lag_pkg.sv
package lag_pkg;
    localparam logic [3:0] SEL_STS    = 4'd0;
    localparam logic [3:0] SEL_INTEN  = 4'd1;
    localparam logic [3:0] SEL_INTVEC = 4'd2;
    localparam logic [3:0] SEL_INTSTA = 4'd3;
    localparam logic [3:0] SEL_INTCAP = 4'd4;
    localparam logic [3:0] SEL_ACCESS = 4'd5;
    localparam logic [3:0] SEL_FIFO   = 4'd6;
    localparam logic [3:0] SEL_CFG    = 4'd7;
    localparam logic [3:0] SEL_HSTART = 4'd8;
    localparam logic [3:0] SEL_HDATA  = 4'd9;
    localparam logic [3:0] SEL_HEND   = 4'd10;

    typedef enum logic [1:0] {
        REL_NONE  = 2'd0,
        REL_SELF  = 2'd1,
        REL_OTHER = 2'd2
    } rel_e;

    typedef enum logic [1:0] {
        OWN_FREE = 2'd0,
        OWN_HELD = 2'd1,
        OWN_HASH = 2'd2
    } own_state_e;
endpackage

// File: rtl/lag_relation.sv
module lag_relation
    import lag_pkg::*;
#(
    parameter int NUM_LOC     = 5,
    parameter int LOC_FIELD_W = 4,
    parameter int LOC_W       = $clog2(NUM_LOC)
) (
    input  logic [LOC_FIELD_W-1:0] loc_nib,
    input  logic                   owner_valid,
    input  logic [LOC_W-1:0]       owner_loc,
    output logic                   loc_ok,
    output logic [LOC_W-1:0]       loc,
    output rel_e                   rel
);
    localparam logic [LOC_FIELD_W-1:0] LOC_LIMIT = LOC_FIELD_W'(NUM_LOC);

    always_comb begin
        loc_ok = (loc_nib < LOC_LIMIT);
        loc    = loc_nib[LOC_W-1:0];
        if (!owner_valid)
            rel = REL_NONE;
        else if (owner_loc == loc)
            rel = REL_SELF;
        else
            rel = REL_OTHER;
    end
endmodule

// File: rtl/lag_permit.sv
module lag_permit
    import lag_pkg::*;
(
    input  logic       loc_ok,
    input  logic [3:0] sel,
    input  logic       write,
    input  logic       avail,
    input  rel_e       rel,
    output logic       permit,
    output logic       is_access_wr,
    output logic       is_int_wr,
    output logic       is_hstart,
    output logic       is_hend
);
    logic self_own;
    logic anyone_or_free;

    always_comb begin
        self_own       = (rel == REL_SELF);
        anyone_or_free = self_own || (rel == REL_NONE);
        permit         = 1'b0;
        unique case (sel)
            SEL_STS:                       permit = self_own;
            SEL_INTEN, SEL_INTVEC, SEL_CFG: permit = write ? self_own : 1'b1;
            SEL_INTSTA:                    permit = write ? self_own : 1'b1;
            SEL_INTCAP:                    permit = !write;
            SEL_ACCESS:                    permit = 1'b1;
            SEL_FIFO:                      permit = self_own && (write || avail);
            SEL_HSTART:                    permit = write && anyone_or_free;
            SEL_HDATA, SEL_HEND:           permit = write && self_own;
            default:                       permit = 1'b0;
        endcase
        permit       = permit && loc_ok;
        is_access_wr = write && (sel == SEL_ACCESS);
        is_int_wr    = write && (sel == SEL_INTSTA);
        is_hstart    = write && (sel == SEL_HSTART);
        is_hend      = write && (sel == SEL_HEND);
    end
endmodule

// File: rtl/lag_owner_fsm.sv
module lag_owner_fsm
    import lag_pkg::*;
#(
    parameter int NUM_LOC  = 5,
    parameter int HASH_LOC = 4,
    parameter int LOC_W    = $clog2(NUM_LOC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_claim,
    input  logic             ev_release,
    input  logic             ev_hstart,
    input  logic             ev_hend,
    input  logic [LOC_W-1:0] ev_loc,
    output logic             owner_valid,
    output logic [LOC_W-1:0] owner_loc
);
    localparam logic [LOC_W-1:0] HLOC = LOC_W'(HASH_LOC);

    own_state_e       state_q, state_d;
    logic [LOC_W-1:0] loc_q, loc_d;
    logic             hend_frees;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OWN_FREE;
            loc_q   <= '0;
        end else begin
            state_q <= state_d;
            loc_q   <= loc_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        loc_d      = loc_q;
        hend_frees = ev_hend && (loc_q == HLOC);
        unique case (state_q)
            OWN_FREE: begin
                if (ev_hstart) begin
                    state_d = OWN_HASH;
                    loc_d   = HLOC;
                end else if (ev_claim) begin
                    state_d = OWN_HELD;
                    loc_d   = ev_loc;
                end
            end
            OWN_HELD: begin
                if (ev_hstart) begin
                    state_d = OWN_HASH;
                    loc_d   = HLOC;
                end else if (ev_release || hend_frees) begin
                    state_d = OWN_FREE;
                    loc_d   = '0;
                end
            end
            OWN_HASH: begin
                if (ev_hstart) begin
                    state_d = OWN_HASH;
                end else if (ev_release || hend_frees) begin
                    state_d = OWN_FREE;
                    loc_d   = '0;
                end
            end
            default: begin
                state_d = OWN_FREE;
                loc_d   = '0;
            end
        endcase
    end

    always_comb begin
        owner_valid = (state_q != OWN_FREE);
        owner_loc   = loc_q;
    end
endmodule

// File: rtl/loc_access_gate.sv
module loc_access_gate
    import lag_pkg::*;
#(
    parameter int NUM_LOC     = 5,
    parameter int LOC_FIELD_W = 4,
    parameter int DATA_W      = 8,
    parameter int HASH_LOC    = 4,
    parameter int CLAIM_BIT   = 0,
    parameter int RELEASE_BIT = 1,
    parameter int LOC_W       = $clog2(NUM_LOC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [LOC_FIELD_W-1:0] req_loc_nib,
    input  logic [3:0]             req_reg,
    input  logic                   req_write,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic                   data_avail,
    output logic                   rsp_valid,
    output logic                   rsp_accept,
    output logic                   rsp_abort,
    output logic                   int_clear,
    output logic [DATA_W-1:0]      int_clear_mask,
    output logic                   owner_valid,
    output logic [LOC_W-1:0]       owner_loc
);
    logic             loc_ok;
    logic [LOC_W-1:0] loc;
    rel_e             rel;
    logic             permit, is_access_wr, is_int_wr, is_hstart, is_hend;
    logic             go;
    logic             ev_claim, ev_release, ev_hstart, ev_hend;

    lag_relation #(.NUM_LOC(NUM_LOC), .LOC_FIELD_W(LOC_FIELD_W), .LOC_W(LOC_W)) u_rel (
        .loc_nib     (req_loc_nib),
        .owner_valid (owner_valid),
        .owner_loc   (owner_loc),
        .loc_ok      (loc_ok),
        .loc         (loc),
        .rel         (rel)
    );

    lag_permit u_permit (
        .loc_ok       (loc_ok),
        .sel          (req_reg),
        .write        (req_write),
        .avail        (data_avail),
        .rel          (rel),
        .permit       (permit),
        .is_access_wr (is_access_wr),
        .is_int_wr    (is_int_wr),
        .is_hstart    (is_hstart),
        .is_hend      (is_hend)
    );

    always_comb begin
        go         = req_valid && permit;
        ev_release = go && is_access_wr && req_wdata[RELEASE_BIT] && (rel == REL_SELF);
        ev_claim   = go && is_access_wr && req_wdata[CLAIM_BIT] && !req_wdata[RELEASE_BIT]
                     && (rel == REL_NONE);
        ev_hstart  = go && is_hstart;
        ev_hend    = go && is_hend;
    end

    lag_owner_fsm #(.NUM_LOC(NUM_LOC), .HASH_LOC(HASH_LOC), .LOC_W(LOC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_claim    (ev_claim),
        .ev_release  (ev_release),
        .ev_hstart   (ev_hstart),
        .ev_hend     (ev_hend),
        .ev_loc      (loc),
        .owner_valid (owner_valid),
        .owner_loc   (owner_loc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_accept     <= 1'b0;
            rsp_abort      <= 1'b0;
            int_clear      <= 1'b0;
            int_clear_mask <= '0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_accept     <= go;
            rsp_abort      <= req_valid && !permit;
            int_clear      <= go && is_int_wr;
            int_clear_mask <= (go && is_int_wr) ? req_wdata : '0;
        end
    end
endmodule

// File: rtl/loc_access_gate_sva.sv
module loc_access_gate_sva
    import lag_pkg::*;
#(
    parameter int NUM_LOC     = 5,
    parameter int LOC_FIELD_W = 4,
    parameter int DATA_W      = 8,
    parameter int HASH_LOC    = 4,
    parameter int LOC_W       = $clog2(NUM_LOC)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [LOC_FIELD_W-1:0] req_loc_nib,
    input logic [3:0]             req_reg,
    input logic                   req_write,
    input logic [DATA_W-1:0]      req_wdata,
    input logic                   data_avail,
    input logic                   rsp_valid,
    input logic                   rsp_accept,
    input logic                   rsp_abort,
    input logic                   int_clear,
    input logic [DATA_W-1:0]      int_clear_mask,
    input logic                   owner_valid,
    input logic [LOC_W-1:0]       owner_loc
);
    localparam logic [LOC_FIELD_W-1:0] LOC_LIMIT = LOC_FIELD_W'(NUM_LOC);
    localparam logic [LOC_W-1:0]       HLOC      = LOC_W'(HASH_LOC);

    assert_rsp_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_one_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_accept != rsp_abort));
    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_accept && !rsp_abort && !int_clear);
    assert_bad_loc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_loc_nib >= LOC_LIMIT) |=> rsp_abort);
    assert_fifo_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_reg == SEL_FIFO && !data_avail) |=> rsp_abort);
    assert_abort_keeps_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> $stable(owner_valid) && $stable(owner_loc) && !int_clear);
    assert_clear_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_clear |-> rsp_accept && (int_clear_mask == $past(req_wdata)));
    assert_hstart_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_accept && $past(req_write) && $past(req_reg) == SEL_HSTART)
        |-> owner_valid && owner_loc == HLOC);
endmodule

bind loc_access_gate loc_access_gate_sva #(
    .NUM_LOC(NUM_LOC), .LOC_FIELD_W(LOC_FIELD_W), .DATA_W(DATA_W), .HASH_LOC(HASH_LOC), .LOC_W(LOC_W)
) u_sva (.*);

// File: tb/loc_access_gate_test.sv
module loc_access_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_loc_nib = '0;
    logic [3:0] req_reg = '0;
    logic       req_write = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       data_avail = 1'b0;
    logic       rsp_valid, rsp_accept, rsp_abort, int_clear;
    logic [7:0] int_clear_mask;
    logic       owner_valid;
    logic [2:0] owner_loc;

    int checks = 0;
    int fails  = 0;

    bit ref_owned = 1'b0;
    int ref_loc   = 0;

    always #5 clk = ~clk;

    loc_access_gate uut (.*);

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int loc, input int sel);
        if (loc > 4) return "R10";
        case (sel)
            0: return "R1";
            1, 2, 7: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            8: return "R7";
            9, 10: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic bit exp_accept(input int loc, input int sel, input bit wr, input bit avail);
        bit own  = ref_owned && (ref_loc == loc);
        bit free = !ref_owned;
        if (loc > 4) return 1'b0;
        case (sel)
            0: return own;
            1, 2, 3, 7: return wr ? own : 1'b1;
            4: return !wr;
            5: return 1'b1;
            6: return own && (wr || avail);
            8: return wr && (own || free);
            9, 10: return wr && own;
            default: return 1'b0;
        endcase
    endfunction

    task automatic issue(input int loc, input int sel, input bit wr, input int wd, input bit avail);
        bit    acc, was_owned, own;
        int    was_loc;
        string t;
        @(negedge clk);
        req_valid   = 1'b1;
        req_loc_nib = 4'(loc);
        req_reg     = 4'(sel);
        req_write   = wr;
        req_wdata   = 8'(wd);
        data_avail  = avail;
        acc       = exp_accept(loc, sel, wr, avail);
        was_owned = ref_owned;
        was_loc   = ref_loc;
        own       = ref_owned && (ref_loc == loc);
        if (acc && wr) begin
            if (sel == 5) begin
                if (wd[1] && own) ref_owned = 1'b0;
                else if (wd[0] && !wd[1] && !ref_owned) begin ref_owned = 1'b1; ref_loc = loc; end
            end else if (sel == 8) begin
                ref_owned = 1'b1; ref_loc = 4;
            end else if (sel == 10 && ref_owned && ref_loc == 4) begin
                ref_owned = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        t = tag_of(loc, sel);
        chk(rsp_valid === 1'b1, "R12", "rsp_valid", int'(rsp_valid), 1);
        chk(rsp_accept === acc && rsp_abort === !acc, t, "accept", int'(rsp_accept), int'(acc));
        chk(int_clear === (acc && wr && sel == 3), "R3", "int_clear", int'(int_clear), int'(acc && wr && sel == 3));
        if (acc && wr && sel == 3)
            chk(int_clear_mask === 8'(wd), "R3", "mask", int'(int_clear_mask), wd);
        if (!acc)
            chk(owner_valid === was_owned && (!was_owned || owner_loc === 3'(was_loc)),
                "R9", "owner after abort", int'(owner_valid), int'(was_owned));
        chk(owner_valid === ref_owned, (sel == 8) ? "R7" : (sel == 10) ? "R8" : "R5",
            "owner_valid", int'(owner_valid), int'(ref_owned));
        if (ref_owned)
            chk(owner_loc === 3'(ref_loc), (sel == 8) ? "R7" : "R5", "owner_loc", int'(owner_loc), ref_loc);
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(rsp_valid === 1'b0 && rsp_accept === 1'b0 && rsp_abort === 1'b0, "R12", "idle response", int'(rsp_valid), 0);
    endtask

    task automatic set_owner(input int want);
        if (ref_owned) issue(ref_loc, 5, 1'b1, 2, 1'b0);
        if (want >= 0) issue(want, 5, 1'b1, 1, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        #1;
        chk(owner_valid === 1'b0, "R11", "owner at reset", int'(owner_valid), 0);
        chk(rsp_valid === 1'b0 && int_clear === 1'b0, "R11", "response at reset", int'(rsp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_check();

        // Directed corner cases
        issue(2, 5, 1'b1, 3, 1'b0);            // R5 claim+relinquish while free: no claim
        issue(2, 5, 1'b1, 1, 1'b0);            // R5 claim
        issue(3, 5, 1'b1, 1, 1'b0);            // R5 claim while held is dropped
        issue(2, 3, 1'b1, 8'hA5, 1'b0);        // R3 owner clear
        issue(1, 3, 1'b1, 8'h5A, 1'b0);        // R3 non-owner write aborts
        issue(2, 8, 1'b1, 0, 1'b0);            // R7 owner hash start moves to loc 4
        issue(4, 9, 1'b1, 0, 1'b0);            // R8 hash data
        issue(4, 10, 1'b1, 0, 1'b0);           // R8 hash end releases
        issue(0, 8, 1'b1, 0, 1'b0);            // R7 hash start while free
        issue(4, 10, 1'b0, 0, 1'b0);           // R8 read aborts
        issue(12, 5, 1'b1, 1, 1'b0);           // R10 bad locality
        idle_check();

        // Sweep every ownership case, locality, register, direction, data status
        for (int ow = -1; ow <= 4; ow++) begin
            for (int l = 0; l < 8; l++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int a = 0; a < 2; a++) begin
                            if (!(ref_owned == (ow >= 0) && (ow < 0 || ref_loc == ow)))
                                set_owner(ow);
                            issue(l, s, w[0], (s == 5) ? 0 : 8'h3C, a[0]);
                        end
                    end
                end
            end
        end

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            issue(int'($urandom_range(0, 5)), int'($urandom_range(0, 11)),
                  1'($urandom), int'($urandom_range(0, 255)), 1'($urandom));
            if (i % 97 == 0) idle_check();
        end

        idle_check();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule